// File: doc/BRIEF.md
# Faulty Lane Power-Down Sequencer

This block takes a receiver lane that has failed its training checks and parks it in a safe, powered-down state. A single-cycle `start` carries the lane index. The block first records the lane in a sticky 32-bit mask. Lane 0 maps to the most significant bit, so a lane with index n sets bit 31−n.

It then drives that lane's control fields through a write port, one field at a time. Each write waits for its acknowledge before the next one starts. The first write aborts any recalibration on the lane. After that, the block reads the lane's busy flag until the lane is idle. Between reads it waits a programmable number of cycles, and it gives up after a bounded number of reads.

Once the lane is idle, the block writes the following in a fixed order:
- the maximum sampling amplitude;
- a set-mask for bit 3 of the lane's A-control field;
- the bank-A select;
- analog power-down;
- digital power-down;
- lane disable;
- forced init-done.

If the busy flag never clears, the block latches a timeout error and stops without writing those fields. Either way, it ends with a one-cycle done pulse and goes back to idle.

Top module: `lane_pd_sequencer`

## Requirements
- R1: After reset, `pdMask` is zero, and `wrValid`, `statRd`, `active`, `done` and `timeoutErr` are all low.
- R2: A start accepted while idle ORs bit (31 − laneIdx) into `pdMask`. Bits are never cleared, so marking a lane twice leaves the mask unchanged.
- R3: The first write of every run targets the started lane with field code 0 (recalibration abort) and data 1. It comes before any busy read.
- R4: While `wrValid` is high and `wrAck` is low, `wrSel`, `wrData` and `tgtLane` hold steady. A write completes on the clock edge where `wrValid` and `wrAck` are both high.
- R5: `statRd` marks a one-cycle busy read that samples `laneBusy`. Consecutive reads are exactly WAIT_CYCLES+1 cycles apart. No read overlaps a write. The run continues after the first read that sees `laneBusy` low, so b busy reads followed by one idle read gives b+1 reads.
- R6: If all MAX_POLLS reads see `laneBusy` high, `timeoutErr` rises together with `done`, and no write follows the abort. `timeoutErr` then stays high until the next accepted start, which clears it.
- R7: After an idle read, exactly seven writes follow on the same lane, in this order: code 1 data 0x7F (amplitude), code 2 data 0x08 (A-control set-mask, bit 3), code 3 data 1 (bank A), code 4 data 1 (analog power-down), code 5 data 1 (digital power-down), code 6 data 1 (disable), code 7 data 1 (force init-done).
- R8: `done` is a one-cycle pulse after which `active` is low. A start that arrives while `active` is high is ignored: the mask does not change and the run goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a power-down run for `laneIdx` (idle only) |
| laneIdx | input | LANE_W | Lane to power down |
| wrValid | output | 1 | Field write request |
| wrSel | output | 3 | Field code of the current write |
| wrData | output | 7 | Field value (set-mask for code 2) |
| tgtLane | output | LANE_W | Lane addressed by writes and busy reads |
| wrAck | input | 1 | Write accepted |
| statRd | output | 1 | Busy read strobe; `laneBusy` sampled this cycle |
| laneBusy | input | 1 | Busy status of `tgtLane` |
| pdMask | output | MASK_W | Sticky powered-down lane mask, lane 0 at MSB |
| active | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeoutErr | output | 1 | Busy poll gave up; held until next start |

## Verification
Two cases are the hardest to reach from the ports.

The first is a lane whose busy flag clears on the very last permitted read. The bench reaches it with a busy model that stays high for a programmed number of reads, set to MAX_POLLS−1. Setting it to MAX_POLLS+3 instead drives the timeout path.

The second is a start that arrives in the middle of a run. The bench injects it while the lane is still being polled and then confirms that the intruding lane never appears in the mask.

Acknowledge latency is varied from run to run, so that writes are held across several cycles.

// File: rtl/lane_pd_pkg.sv
package lane_pd_pkg;

  // Field codes on the write port; the order of codes 1..7 is the
  // order in which they are issued after the lane goes idle.
  typedef enum logic [2:0] {
    SEL_ABORT    = 3'd0,
    SEL_AMP      = 3'd1,
    SEL_ACTL     = 3'd2,
    SEL_BANKA    = 3'd3,
    SEL_ANA_PD   = 3'd4,
    SEL_DIG_PD   = 3'd5,
    SEL_DISABLE  = 3'd6,
    SEL_INITDONE = 3'd7
  } fieldSel_e;

  localparam logic [6:0] AMP_MAX      = 7'h7F;
  localparam logic [6:0] ACTL_SET_BIT = 7'h08;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_POLL,
    ST_WAIT,
    ST_DONE
  } seqState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic captureLane;
    logic clearErr;
    logic raiseErr;
    logic clearPolls;
    logic bumpPoll;
    logic clearWait;
    logic bumpWait;
  } dpStrobe_t;

endpackage

// File: rtl/lane_pd_datapath.sv
module lane_pd_datapath
  import lane_pd_pkg::*;
#(
  parameter int MASK_W      = 32,
  parameter int WAIT_CYCLES = 50000,
  parameter int MAX_POLLS   = 200,
  localparam int LANE_W     = $clog2(MASK_W),
  localparam int WAIT_W     = $clog2(WAIT_CYCLES + 1),
  localparam int POLL_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [LANE_W-1:0] laneIdx,
  input  fieldSel_e         curSel,
  output logic [LANE_W-1:0] curLane,
  output logic [6:0]        fieldData,
  output logic [MASK_W-1:0] pdMask,
  output logic              timeoutErr,
  output logic              pollLast,
  output logic              waitDone
);

  localparam logic [MASK_W-1:0] TOP_BIT   = {1'b1, {(MASK_W-1){1'b0}}};
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pdMask     <= '0;
      curLane    <= '0;
      timeoutErr <= 1'b0;
    end else begin
      if (strobe.captureLane) begin
        curLane <= laneIdx;
        pdMask  <= pdMask | (TOP_BIT >> laneIdx);
      end
      if (strobe.clearErr)      timeoutErr <= 1'b0;
      else if (strobe.raiseErr) timeoutErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      pollCnt <= '0;
    end else begin
      if (strobe.clearWait)     waitCnt <= '0;
      else if (strobe.bumpWait) waitCnt <= waitCnt + 1'b1;
      if (strobe.clearPolls)    pollCnt <= '0;
      else if (strobe.bumpPoll) pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pollLast = (pollCnt == POLL_LAST);
  assign waitDone = (waitCnt == WAIT_LAST);

  always_comb begin
    unique case (curSel)
      SEL_AMP:  fieldData = AMP_MAX;
      SEL_ACTL: fieldData = ACTL_SET_BIT;
      default:  fieldData = 7'd1;
    endcase
  end

endmodule

// File: rtl/lane_pd_control.sv
module lane_pd_control
  import lane_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      wrAck,
  input  logic      laneBusy,
  input  logic      pollLast,
  input  logic      waitDone,
  output dpStrobe_t strobe,
  output fieldSel_e curSel,
  output logic      wrValid,
  output logic      statRd,
  output logic      active,
  output logic      done
);

  seqState_e state, nextState;
  fieldSel_e step;
  logic      stepAdvance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= SEL_ABORT;
    end else begin
      state <= nextState;
      if (state == ST_IDLE)  step <= SEL_ABORT;
      else if (stepAdvance)  step <= fieldSel_e'(step + 3'd1);
    end
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    stepAdvance = 1'b0;
    wrValid     = 1'b0;
    statRd      = 1'b0;
    done        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.captureLane = 1'b1;
          strobe.clearErr    = 1'b1;
          nextState          = ST_WRITE;
        end
      end
      ST_WRITE: begin
        wrValid = 1'b1;
        if (wrAck) begin
          stepAdvance = 1'b1;
          if (step == SEL_ABORT) begin
            strobe.clearPolls = 1'b1;
            strobe.clearWait  = 1'b1;
            nextState         = ST_POLL;
          end else if (step == SEL_INITDONE) begin
            nextState = ST_DONE;
          end
        end
      end
      ST_POLL: begin
        statRd = 1'b1;
        if (!laneBusy) begin
          nextState = ST_WRITE;
        end else if (pollLast) begin
          strobe.raiseErr = 1'b1;
          nextState       = ST_DONE;
        end else begin
          strobe.clearWait = 1'b1;
          nextState        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (waitDone) begin
          strobe.clearWait = 1'b1;
          strobe.bumpPoll  = 1'b1;
          nextState        = ST_POLL;
        end else begin
          strobe.bumpWait = 1'b1;
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign curSel = step;
  assign active = (state != ST_IDLE);

endmodule

// File: rtl/lane_pd_sequencer.sv
module lane_pd_sequencer
  import lane_pd_pkg::*;
#(
  parameter int MASK_W      = 32,
  parameter int WAIT_CYCLES = 50000,
  parameter int MAX_POLLS   = 200,
  localparam int LANE_W     = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LANE_W-1:0] laneIdx,
  output logic              wrValid,
  output logic [2:0]        wrSel,
  output logic [6:0]        wrData,
  output logic [LANE_W-1:0] tgtLane,
  input  logic              wrAck,
  output logic              statRd,
  input  logic              laneBusy,
  output logic [MASK_W-1:0] pdMask,
  output logic              active,
  output logic              done,
  output logic              timeoutErr
);

  dpStrobe_t strobe;
  fieldSel_e curSel;
  logic      pollLast;
  logic      waitDone;

  lane_pd_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wrAck    (wrAck),
    .laneBusy (laneBusy),
    .pollLast (pollLast),
    .waitDone (waitDone),
    .strobe   (strobe),
    .curSel   (curSel),
    .wrValid  (wrValid),
    .statRd   (statRd),
    .active   (active),
    .done     (done)
  );

  lane_pd_datapath #(
    .MASK_W      (MASK_W),
    .WAIT_CYCLES (WAIT_CYCLES),
    .MAX_POLLS   (MAX_POLLS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .laneIdx    (laneIdx),
    .curSel     (curSel),
    .curLane    (tgtLane),
    .fieldData  (wrData),
    .pdMask     (pdMask),
    .timeoutErr (timeoutErr),
    .pollLast   (pollLast),
    .waitDone   (waitDone)
  );

  assign wrSel = curSel;

endmodule

// File: rtl/lane_pd_sequencer_chk.sv
module lane_pd_sequencer_chk #(
  parameter int MASK_W      = 32,
  parameter int WAIT_CYCLES = 50000,
  localparam int LANE_W     = $clog2(MASK_W),
  localparam int GAP_W      = $clog2(WAIT_CYCLES + 3)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wrValid,
  input logic              wrAck,
  input logic [2:0]        wrSel,
  input logic [6:0]        wrData,
  input logic [LANE_W-1:0] tgtLane,
  input logic              statRd,
  input logic [MASK_W-1:0] pdMask,
  input logic              active,
  input logic              done,
  input logic              timeoutErr
);

  localparam logic [GAP_W-1:0] GAP_EXP = GAP_W'(WAIT_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic             seenRd;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      seenRd <= 1'b0;
      gapCnt <= '0;
    end else if (statRd) begin
      seenRd <= 1'b1;
      gapCnt <= GAP_W'(1);
    end else if (gapCnt != GAP_MAX) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) && !rstN |-> !wrValid && !statRd && !done && !timeoutErr);

  // R2
  mask_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdMask & $past(pdMask)) == $past(pdMask));

  // R3
  abort_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> wrValid && wrSel == 3'd0 && wrData == 7'd1);

  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrAck |=> wrValid && $stable(wrSel) && $stable(wrData) && $stable(tgtLane));

  // R5
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRd && seenRd |-> gapCnt == GAP_EXP);

  // R5
  no_read_during_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> !wrValid);

  // R6
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !active);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && start |=> $stable(pdMask));

endmodule

bind lane_pd_sequencer lane_pd_sequencer_chk #(
  .MASK_W      (MASK_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .wrValid    (wrValid),
  .wrAck      (wrAck),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .tgtLane    (tgtLane),
  .statRd     (statRd),
  .pdMask     (pdMask),
  .active     (active),
  .done       (done),
  .timeoutErr (timeoutErr)
);

// File: tb/lane_pd_sequencer_test.sv
`timescale 1ns/1ps
module lane_pd_sequencer_test;

  localparam int TB_WAIT  = 3;
  localparam int TB_POLLS = 6;

  typedef struct {
    logic [2:0] sel;
    logic [6:0] data;
    logic [4:0] lane;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  laneIdx = '0;
  logic        wrValid;
  logic [2:0]  wrSel;
  logic [6:0]  wrData;
  logic [4:0]  tgtLane;
  logic        wrAck = 1'b0;
  logic        statRd;
  logic        laneBusy;
  logic [31:0] pdMask;
  logic        active;
  logic        done;
  logic        timeoutErr;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  int ackLat = 0;
  int ackCnt = 0;
  int busyRemain = 0;
  bit pendingDec = 0;
  int reads = 0;
  int lastRd = -1;
  logic [31:0] expMask = '0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  assign laneBusy = (busyRemain != 0);

  lane_pd_sequencer #(
    .MASK_W      (32),
    .WAIT_CYCLES (TB_WAIT),
    .MAX_POLLS   (TB_POLLS)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .laneIdx    (laneIdx),
    .wrValid    (wrValid),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .tgtLane    (tgtLane),
    .wrAck      (wrAck),
    .statRd     (statRd),
    .laneBusy   (laneBusy),
    .pdMask     (pdMask),
    .active     (active),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write acknowledge responder and busy model.
  always @(negedge clk) begin
    if (pendingDec) begin
      if (busyRemain > 0) busyRemain--;
      pendingDec = 0;
    end
    if (wrValid && !wrAck) begin
      if (ackCnt >= ackLat) wrAck = 1'b1;
      else ackCnt++;
    end else begin
      wrAck  = 1'b0;
      ackCnt = 0;
    end
  end

  // Monitor: pops expected writes and checks busy-read spacing.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      cycle++;
      if (wrValid && wrAck) begin
        if (expQ.size() == 0) begin
          check(0, "R6/R7 unexpected write", wrSel, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(wrSel == e.sel, "R3/R7 write code", wrSel, e.sel);
          check(wrData == e.data, "R3/R7 write data", wrData, e.data);
          check(tgtLane == e.lane, "R3/R7 write lane", tgtLane, e.lane);
        end
      end
      if (statRd) begin
        reads++;
        if (lastRd >= 0)
          check(cycle - lastRd == TB_WAIT + 1, "R5 read spacing", cycle - lastRd, TB_WAIT + 1);
        lastRd = cycle;
        if (laneBusy) pendingDec = 1;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic pushItem(input logic [2:0] s, input logic [6:0] d, input logic [4:0] l);
    expItem_t e;
    e.sel = s; e.data = d; e.lane = l;
    expQ.push_back(e);
  endtask

  // Driver: queues expected writes, starts a run and checks its end state.
  task automatic runSeq(input int lane, input int busyN, input int lat, input int intrude);
    bit tmo;
    int expReads;
    bit seenDone;
    tmo = (busyN >= TB_POLLS);
    expReads = tmo ? TB_POLLS : busyN + 1;
    ackLat = lat;
    busyRemain = busyN;
    reads = 0;
    lastRd = -1;
    pushItem(3'd0, 7'd1, 5'(lane));
    if (!tmo) begin
      pushItem(3'd1, 7'h7F, 5'(lane));
      pushItem(3'd2, 7'h08, 5'(lane));
      for (int c = 3; c < 8; c++) pushItem(3'(c), 7'd1, 5'(lane));
    end
    expMask |= (32'h8000_0000 >> lane);
    @(negedge clk);
    start = 1'b1;
    laneIdx = 5'(lane);
    @(negedge clk);
    start = 1'b0;
    #5;
    check(timeoutErr == 1'b0, "R6 cleared by start", timeoutErr, 0);
    check(active == 1'b1, "R8 active after start", active, 1);
    if (intrude >= 0) begin
      @(negedge clk);
      start = 1'b1;
      laneIdx = 5'(intrude);
      @(negedge clk);
      start = 1'b0;
    end
    seenDone = 0;
    for (int i = 0; i < 2000 && !seenDone; i++) begin
      @(negedge clk);
      #5;
      if (done) seenDone = 1;
    end
    check(seenDone, "R8 done seen", seenDone, 1);
    check(expQ.size() == 0, "R7 all writes issued", expQ.size(), 0);
    check(timeoutErr == tmo, "R6 timeout flag", timeoutErr, tmo);
    check(reads == expReads, "R5 busy read count", reads, expReads);
    check(pdMask == expMask, "R2 mask", pdMask, expMask);
    @(negedge clk);
    #5;
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(active == 1'b0, "R8 idle after done", active, 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check(pdMask == 32'h0, "R1 mask reset", pdMask, 0);
    check(!wrValid && !statRd, "R1 port idle", {wrValid, statRd}, 0);
    check(!active && !done && !timeoutErr, "R1 status reset", {active, done, timeoutErr}, 0);
    @(negedge clk);
    rstN = 1'b1;

    runSeq(3, 0, 0, -1);             // idle at first read
    runSeq(31, 2, 2, -1);            // LSB lane, slow acks
    runSeq(0, TB_POLLS + 3, 1, -1);  // R6 timeout path, MSB lane
    repeat (5) @(negedge clk);
    #5;
    check(timeoutErr == 1'b1, "R6 error held while idle", timeoutErr, 1);
    check(pdMask == expMask, "R6 lane still marked", pdMask, expMask);
    runSeq(3, 1, 0, -1);             // R2 repeat lane, mask unchanged
    runSeq(17, 2, 0, 9);             // R8 start while active ignored
    check(pdMask[31-9] == 1'b0, "R8 intruding lane not marked", pdMask[31-9], 0);
    runSeq(16, TB_POLLS - 1, 3, -1); // R5 idle on last permitted read

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule